// File: doc/BRIEF.md
# External Bus Interface Controller

This controller turns single read or write requests from the internal side into timed cycles on a 16-bit external bus. An 18-bit request address is split into a basic region and three 64-kbyte windows, and a mapping register assigns each window to one of three numbered areas. Areas 1, 2 and 3 each drive a dedicated chip select; the basic area drives none. Timing comes from three setting groups: group 0 is shared by the basic area and area 1, and areas 2 and 3 each have a group of their own. A group selects a 2-state or 3-state access, adds 0 to 3 wait states ahead of the final state, and can invert the level of its chip select.

The pins work in one of two ways. In separate mode the address appears on its own 16 pins and data on the shared data pins. In multiplexed mode an address phase comes first: the address is driven on the data pins and the address hold strobe is asserted, and the data phase follows. One global bit inverts both the address strobe and the address hold strobe. When a write comes directly after a read, the controller can add one idle cycle before the write starts.

The sequencer uses these states. `S_IDLE` waits for a request. `S_GAP` is the forced idle cycle. `S_ADR` is the multiplexed address phase. `S_T1` is the first access state and `S_T2` the middle state of a 3-state access. `S_WT` is a wait state. `S_TL` is the last state. The transitions are: IDLE→GAP (write after read with idle insertion enabled), IDLE→ADR (multiplexed mode), IDLE→T1 (all other requests), GAP→ADR or GAP→T1 (depending on mode), ADR→T1, T1→T2 (3-state), T1 or T2→WT (wait count nonzero), T1 or T2→TL (no waits), WT→WT until the wait count is used up, WT→TL, and TL→IDLE.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, ack is 0, ext_ad_oe is 0, and ext_cs_n, ext_as_n, ext_ah_n, ext_rd_n and ext_wr_n are all 1.
- R2: req_addr[17:16] picks the window. Value 0 is the basic area. Values 1 to 3 pick window 0 to 2, and the map register gives each window a 2-bit area code (config select 1, bits [2i+1:2i] for window i, reset value 3'd… 1, 2, 3 for windows 0, 1, 2). Area code 0 means the basic area.
- R3: During a cycle (address phase through last state), area n asserts only ext_cs_n[n-1]. A basic-area cycle asserts no chip select.
- R4: Group 0 (config select 2) times the basic area and area 1. Group 1 (select 3) times area 2. Group 2 (select 4) times area 3. Group bits: [0] 3-state, [2:1] wait count, [3] chip-select invert. Reset is 3-state, no waits, no invert.
- R5: The address strobe is asserted for 2 cycles in a 2-state access and 3 in a 3-state access, plus any wait states.
- R6: Each wait count of 0 to 3 extends the strobe by that many cycles, inserted before the last state.
- R7: Mode register (config select 0): bit 0 selects multiplexed mode, bit 1 inverts the strobes, bit 2 enables idle insertion. Reset value is 3'b100. In separate mode, req_addr[15:0] is on ext_addr during the cycle.
- R8: In multiplexed mode, one address-phase cycle comes before the strobe. In that cycle ext_ah_n is asserted, ext_ad_out carries the address with ext_ad_oe high, and ext_addr is 0.
- R9: In back-to-back requests there are 2 bus-dead cycles between cycles. There are 3 when idle insertion is enabled and a write directly follows a read. Every other combination gets 2.
- R10: Group bit 3 inverts the level of that group's chip select (CS1 from group 0, CS2 from group 1, CS3 from group 2). Mode bit 1 inverts both ext_as_n and ext_ah_n.
- R11: ack is a one-cycle pulse in the cycle after the last state. For a read, rd_data then holds the ext_ad_in value sampled in the last state. No new cycle starts while ack is high.
- R12: A write drives its data on ext_ad_out with ext_ad_oe high while ext_wr_n is low. ext_wr_n is low from the second access state through the last. During a read, ext_ad_oe stays low in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (0 mode, 1 map, 2..4 groups) |
| cfg_wdata | input | 8 | Configuration write data |
| req | input | 1 | Transfer request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Transfer complete pulse |
| rd_data | output | 16 | Read data |
| ext_addr | output | 16 | External address pins (separate mode) |
| ext_ad_out | output | 16 | Shared data/address pins, output value |
| ext_ad_oe | output | 1 | Output enable for the shared pins |
| ext_ad_in | input | 16 | Shared data pins, input value |
| ext_cs_n | output | 3 | Chip selects for areas 1..3 |
| ext_as_n | output | 1 | Address strobe |
| ext_ah_n | output | 1 | Address hold strobe |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |

## Verification
The assertions rely on the internal side keeping req, req_wr, req_addr and req_wdata steady from the request until ack. They also rely on no configuration register being written while a cycle is in flight. The scoreboard bench follows both rules. Each request is raised on a falling edge and dropped on the falling edge where ack is seen. Configuration writes happen only between requests. Every decode, timing and polarity expectation is derived from the bench's own copy of the register values.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int WAIT_W = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_ADR,
        S_T1,
        S_T2,
        S_WT,
        S_TL
    } seq_state_t;

    // group register layout: [3] chip-select invert, [2:1] waits, [0] 3-state
    typedef struct packed {
        logic              cs_inv;
        logic [WAIT_W-1:0] waits;
        logic              three_st;
    } grp_cfg_t;

    // mode register layout: [2] idle insertion, [1] strobe invert, [0] multiplexed
    typedef struct packed {
        logic idle_en;
        logic strobe_inv;
        logic mux_en;
    } mode_cfg_t;
endpackage

// File: rtl/ebc_regs.sv
module ebc_regs
    import ebc_pkg::*;
#(
    parameter int N_AREA = 3,
    parameter int MAP_W  = 2,
    parameter int SEL_W  = 3,
    parameter int CFG_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output mode_cfg_t                 mode,
    output logic [N_AREA*MAP_W-1:0]   win_map,
    output grp_cfg_t [N_AREA-1:0]     grp
);
    localparam int SEL_MODE = 0;
    localparam int SEL_MAP  = 1;
    localparam int SEL_GRP0 = 2;
    localparam int MODE_W   = $bits(mode_cfg_t);
    localparam int GRP_W    = $bits(grp_cfg_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '{idle_en: 1'b1, strobe_inv: 1'b0, mux_en: 1'b0};
        end else if (cfg_we && cfg_sel == SEL_W'(SEL_MODE)) begin
            mode <= mode_cfg_t'(cfg_wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AREA; i++) begin
                win_map[i*MAP_W +: MAP_W] <= MAP_W'(i + 1);
            end
        end else if (cfg_we && cfg_sel == SEL_W'(SEL_MAP)) begin
            win_map <= cfg_wdata[N_AREA*MAP_W-1:0];
        end
    end

    for (genvar g = 0; g < N_AREA; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp[g] <= '{cs_inv: 1'b0, waits: '0, three_st: 1'b1};
            end else if (cfg_we && cfg_sel == SEL_W'(SEL_GRP0 + g)) begin
                grp[g] <= grp_cfg_t'(cfg_wdata[GRP_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/ebc_decode.sv
module ebc_decode
    import ebc_pkg::*;
#(
    parameter int WIN_W  = 2,
    parameter int N_AREA = 3,
    parameter int MAP_W  = 2
) (
    input  logic [WIN_W-1:0]          win,
    input  logic [N_AREA*MAP_W-1:0]   win_map,
    input  grp_cfg_t [N_AREA-1:0]     grp,
    output logic [N_AREA-1:0]         cs_sel,
    output grp_cfg_t                  sel_cfg
);
    logic [MAP_W-1:0] area;

    always_comb begin
        area = '0;
        if (win != '0) begin
            area = win_map[(int'(win) - 1)*MAP_W +: MAP_W];
        end
    end

    // basic area and area 1 share group 0
    always_comb begin
        if (area <= MAP_W'(1)) begin
            sel_cfg = grp[0];
        end else begin
            sel_cfg = grp[int'(area) - 1];
        end
    end

    for (genvar i = 0; i < N_AREA; i++) begin : g_cs
        assign cs_sel[i] = (area == MAP_W'(i + 1));
    end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_AW = 16,
    parameter int N_AREA = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_wr,
    input  logic [EXT_AW-1:0]   addr_lo,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   ad_in,
    input  mode_cfg_t           mode,
    input  logic                three_st,
    input  logic [WAIT_W-1:0]   waits,
    input  logic [N_AREA-1:0]   cs_sel,
    input  logic [N_AREA-1:0]   cs_inv,
    output logic                ack,
    output logic [DATA_W-1:0]   rd_data,
    output logic [EXT_AW-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [N_AREA-1:0]   cs_n,
    output logic                as_n,
    output logic                ah_n,
    output logic                rd_n,
    output logic                wr_n
);
    seq_state_t          state_q, state_d;
    logic                r_wr, r_mux, r_three;
    logic [WAIT_W-1:0]   r_wait, wcnt_q;
    logic [N_AREA-1:0]   r_cs;
    logic [EXT_AW-1:0]   r_addr;
    logic [DATA_W-1:0]   r_wdata, rd_q;
    logic                ack_q, last_rd_q;
    logic                start, need_gap;

    assign start    = req && !ack_q && (state_q == S_IDLE);
    assign need_gap = mode.idle_en && req_wr && last_rd_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (need_gap)          state_d = S_GAP;
                    else if (mode.mux_en)  state_d = S_ADR;
                    else                   state_d = S_T1;
                end
            end
            S_GAP:  state_d = r_mux ? S_ADR : S_T1;
            S_ADR:  state_d = S_T1;
            S_T1: begin
                if (r_three)               state_d = S_T2;
                else if (r_wait != '0)     state_d = S_WT;
                else                       state_d = S_TL;
            end
            S_T2:   state_d = (r_wait != '0) ? S_WT : S_TL;
            S_WT:   state_d = (wcnt_q == r_wait - WAIT_W'(1)) ? S_TL : S_WT;
            S_TL:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture, wait counter, completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_wr      <= 1'b0;
            r_mux     <= 1'b0;
            r_three   <= 1'b0;
            r_wait    <= '0;
            r_cs      <= '0;
            r_addr    <= '0;
            r_wdata   <= '0;
            wcnt_q    <= '0;
            ack_q     <= 1'b0;
            rd_q      <= '0;
            last_rd_q <= 1'b0;
        end else begin
            if (start) begin
                r_wr    <= req_wr;
                r_mux   <= mode.mux_en;
                r_three <= three_st;
                r_wait  <= waits;
                r_cs    <= cs_sel;
                r_addr  <= addr_lo;
                r_wdata <= wdata;
            end
            if (state_q == S_WT) wcnt_q <= wcnt_q + WAIT_W'(1);
            else                 wcnt_q <= '0;
            ack_q <= (state_q == S_TL);
            if (state_q == S_TL) begin
                last_rd_q <= !r_wr;
                if (!r_wr) rd_q <= ad_in;
            end
            if (state_q == S_TL && r_wr) begin
                r_cs <= '0;
            end else if (state_q == S_TL) begin
                r_cs <= '0;
            end
        end
    end

    // pin outputs
    always_comb begin
        logic data_ph, sel_ph, wr_ph;
        data_ph  = (state_q == S_T1) || (state_q == S_T2) ||
                   (state_q == S_WT) || (state_q == S_TL);
        wr_ph    = (state_q == S_T2) || (state_q == S_WT) || (state_q == S_TL);
        sel_ph   = data_ph || (state_q == S_ADR);
        as_n     = !data_ph ^ mode.strobe_inv;
        ah_n     = !(state_q == S_ADR) ^ mode.strobe_inv;
        rd_n     = !(data_ph && !r_wr);
        wr_n     = !(wr_ph && r_wr);
        cs_n     = ~(r_cs & {N_AREA{sel_ph}}) ^ cs_inv;
        ext_addr = r_mux ? '0 : r_addr;
        ad_out   = (state_q == S_ADR) ? DATA_W'(r_addr) : r_wdata;
        ad_oe    = (state_q == S_ADR) || (data_ph && r_wr);
        ack      = ack_q;
        rd_data  = rd_q;
    end

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);
    a_r11_no_start_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> (state_q == S_IDLE));
    a_r5_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TL) |=> (state_q == S_IDLE));
    a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WT) |-> (wcnt_q < r_wait));
    a_r8_adr_needs_mux: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADR) |-> r_mux);
    a_r9_gap_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |-> (r_wr && last_rd_q && mode.idle_en));
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_cs));
    a_r12_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_wr && !rd_n) |-> !ad_oe);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int EXT_AW = 16,
    parameter int DATA_W = 16,
    parameter int N_AREA = 3,
    parameter int MAP_W  = 2,
    parameter int SEL_W  = 3,
    parameter int CFG_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                req,
    input  logic                req_wr,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                ack,
    output logic [DATA_W-1:0]   rd_data,
    output logic [EXT_AW-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ext_ad_out,
    output logic                ext_ad_oe,
    input  logic [DATA_W-1:0]   ext_ad_in,
    output logic [N_AREA-1:0]   ext_cs_n,
    output logic                ext_as_n,
    output logic                ext_ah_n,
    output logic                ext_rd_n,
    output logic                ext_wr_n
);
    localparam int WIN_W = ADDR_W - EXT_AW;

    mode_cfg_t               mode;
    logic [N_AREA*MAP_W-1:0] win_map;
    grp_cfg_t [N_AREA-1:0]   grp;
    grp_cfg_t                sel_cfg;
    logic [N_AREA-1:0]       cs_sel;
    logic [N_AREA-1:0]       cs_inv;

    for (genvar i = 0; i < N_AREA; i++) begin : g_inv
        assign cs_inv[i] = grp[i].cs_inv;
    end

    ebc_regs #(
        .N_AREA(N_AREA), .MAP_W(MAP_W), .SEL_W(SEL_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode(mode), .win_map(win_map), .grp(grp)
    );

    ebc_decode #(
        .WIN_W(WIN_W), .N_AREA(N_AREA), .MAP_W(MAP_W)
    ) u_dec (
        .win(req_addr[ADDR_W-1:EXT_AW]), .win_map(win_map), .grp(grp),
        .cs_sel(cs_sel), .sel_cfg(sel_cfg)
    );

    ebc_seq #(
        .DATA_W(DATA_W), .EXT_AW(EXT_AW), .N_AREA(N_AREA)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .addr_lo(req_addr[EXT_AW-1:0]), .wdata(req_wdata), .ad_in(ext_ad_in),
        .mode(mode), .three_st(sel_cfg.three_st), .waits(sel_cfg.waits),
        .cs_sel(cs_sel), .cs_inv(cs_inv),
        .ack(ack), .rd_data(rd_data), .ext_addr(ext_addr), .ad_out(ext_ad_out),
        .ad_oe(ext_ad_oe), .cs_n(ext_cs_n), .as_n(ext_as_n), .ah_n(ext_ah_n),
        .rd_n(ext_rd_n), .wr_n(ext_wr_n)
    );
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0, ext_ad_in = '0;
    logic        ack, ext_ad_oe, ext_as_n, ext_ah_n, ext_rd_n, ext_wr_n;
    logic [15:0] rd_data, ext_addr, ext_ad_out;
    logic [2:0]  ext_cs_n;

    always #2.5 clk = ~clk;

    ext_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .ext_addr(ext_addr),
        .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
        .ext_cs_n(ext_cs_n), .ext_as_n(ext_as_n), .ext_ah_n(ext_ah_n),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // configuration mirror
    bit       m_mux = 0, m_sinv = 0, m_idle = 1;
    int       m_map[3] = '{1, 2, 3};
    bit       m_three[3] = '{1, 1, 1};
    int       m_wait[3] = '{0, 0, 0};
    bit       m_csinv[3] = '{0, 0, 0};
    bit       chained = 0, last_rd = 0;

    typedef struct {
        int cs_pins; int addr; int wdata; bit wr; int len; int gap;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic cfg(input int sel, input int val);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 8'(val);
        @(posedge clk);
        case (sel)
            0: begin m_mux = val[0]; m_sinv = val[1]; m_idle = val[2]; end
            1: for (int i = 0; i < 3; i++) m_map[i] = (val >> (2*i)) & 3;
            default: begin
                m_three[sel-2] = val[0];
                m_wait[sel-2]  = (val >> 1) & 3;
                m_csinv[sel-2] = val[3];
            end
        endcase
        @(negedge clk);
        cfg_we = 0;
        chained = 0;
    endtask

    task automatic txn(input bit wr, input int addr, input int data);
        exp_t e;
        int w, area, g;
        w = (addr >> 16) & 3;
        area = (w == 0) ? 0 : m_map[w-1];
        g = (area <= 1) ? 0 : area - 1;
        e.len = (m_mux ? 1 : 0) + (m_three[g] ? 3 : 2) + m_wait[g];
        e.cs_pins = 0;
        for (int i = 0; i < 3; i++)
            e.cs_pins |= (((area == i + 1) ? 0 : 1) ^ int'(m_csinv[i])) << i;
        e.addr = addr & 16'hFFFF;
        e.wdata = data & 16'hFFFF;
        e.wr = wr;
        e.gap = chained ? 2 + ((m_idle && wr && last_rd) ? 1 : 0) : -1;
        q.push_back(e);
        ext_ad_in = wr ? 16'h0 : 16'(data);
        req = 1; req_wr = wr; req_addr = 18'(addr); req_wdata = 16'(data);
        do @(negedge clk); while (!ack);
        if (!wr) chk(rd_data == 16'(data), "R11", "read data", rd_data, data);
        req = 0;
        chained = 1;
        last_rd = !wr;
    endtask

    task automatic rest(input int n);
        repeat (n) @(negedge clk);
        chained = 0;
    endtask

    // monitor: observes bus cycles and compares with the scoreboard
    initial begin
        bit in_act = 0, act, oebad = 0, wseen = 0;
        int len = 0, dead = 0, f_cs = 0, f_addr = 0, f_wd = 0, f_gap = 0;
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            act = (ext_as_n == m_sinv) || (ext_ah_n == m_sinv);
            if (act && !in_act) begin
                in_act = 1; len = 0; oebad = 0; wseen = 0;
                f_cs = ext_cs_n; f_gap = dead;
                if (ext_ah_n == m_sinv) begin
                    f_addr = ext_ad_out;
                    if (!ext_ad_oe || ext_addr != 0) oebad = 1;
                end else begin
                    f_addr = ext_addr;
                end
            end
            if (act) begin
                len++;
                if (!ext_wr_n) begin
                    wseen = 1; f_wd = ext_ad_out;
                    if (!ext_ad_oe) oebad = 1;
                end
                if (!ext_rd_n && ext_ad_oe) oebad = 1;
            end else begin
                if (in_act) begin
                    in_act = 0;
                    if (q.size() == 0) begin
                        chk(0, "R11", "unexpected cycle", len, 0);
                    end else begin
                        e = q.pop_front();
                        chk(f_cs == e.cs_pins, "R3", "chip selects", f_cs, e.cs_pins);
                        chk(f_addr == e.addr, "R7", "address", f_addr, e.addr);
                        chk(len == e.len, "R5", "cycle length", len, e.len);
                        if (e.gap >= 0)
                            chk(f_gap == e.gap, "R9", "dead cycles", f_gap, e.gap);
                        chk(!oebad, "R8", "output enable", oebad, 0);
                        chk(wseen == e.wr, "R12", "write strobe", wseen, e.wr);
                        if (e.wr) chk(f_wd == e.wdata, "R12", "write data", f_wd, e.wdata);
                    end
                    dead = 0;
                end
                dead++;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ack == 0, "R1", "ack", ack, 0);
        chk(ext_cs_n == 3'b111, "R1", "cs", ext_cs_n, 7);
        chk({ext_as_n, ext_ah_n, ext_rd_n, ext_wr_n} == 4'hF, "R1", "strobes",
            {ext_as_n, ext_ah_n, ext_rd_n, ext_wr_n}, 15);
        chk(ext_ad_oe == 0, "R1", "oe", ext_ad_oe, 0);

        // defaults: separate, 3-state, no waits; R2 R9 write after read
        txn(0, 18'h0_1234, 16'hA1B2);
        txn(1, 18'h1_0010, 16'h1111);
        txn(1, 18'h2_0020, 16'h2222);
        txn(0, 18'h3_FFFE, 16'h3333);
        txn(0, 18'h1_4444, 16'h4444);
        rest(3);

        // R4 R6 per-group timing
        cfg(2, 8'b0010);
        cfg(3, 8'b0101);
        cfg(4, 8'b0110);
        txn(0, 18'h0_0100, 16'h5151);
        txn(1, 18'h1_0200, 16'h5252);
        txn(0, 18'h2_0300, 16'h5353);
        txn(1, 18'h3_0400, 16'h5454);
        rest(2);

        // R2 remap: window0->3, window1->basic, window2->2
        cfg(1, 8'h23);
        txn(1, 18'h1_0A0A, 16'h6161);
        txn(0, 18'h2_0B0B, 16'h6262);
        txn(1, 18'h3_0C0C, 16'h6363);
        rest(2);

        // R10 polarity
        cfg(3, 8'b1101);
        cfg(0, 8'b110);
        txn(0, 18'h3_1357, 16'h7171);
        txn(1, 18'h1_2468, 16'h7272);
        txn(0, 18'h2_0001, 16'h7373);
        rest(2);

        // R8 multiplexed mode, idle insertion on
        cfg(0, 8'b101);
        txn(0, 18'h3_ABCD, 16'h8181);
        txn(1, 18'h1_BEEF, 16'h8282);
        txn(1, 18'h0_0042, 16'h8383);
        rest(2);

        // R9 idle insertion off
        cfg(0, 8'b001);
        txn(0, 18'h2_5555, 16'h9191);
        txn(1, 18'h2_6666, 16'h9292);
        rest(2);

        // back to separate mode, write after read with insertion off
        cfg(0, 8'b000);
        txn(0, 18'h1_7777, 16'hA0A0);
        txn(1, 18'h3_8888, 16'hA1A1);

        rest(6);
        chk(q.size() == 0, "R11", "pending items", q.size(), 0);
        finish_run();
    end
endmodule